// File: doc/BRIEF.md
# Dual Lookup Table DAC Code Selector

This block feeds two current-output DAC channels from two small byte tables, one table per channel. Each table holds 64 entries. For every channel the row read from its table is picked from one of two places: the top six bits of the on-chip ADC result, which gives a temperature- or sense-driven curve, or a six-bit row number that the host writes directly. A per-channel enable bit chooses between them. The byte stored in the chosen row is registered and becomes that channel's DAC input code.

A host write port loads table entries one byte at a time. A write that lands on the row a channel is reading shows up on that channel's output at the same clock edge that stores it. Until a power-up-complete input is high, both DAC codes are held at 00h so that the analog outputs stay at zero while the tables are being filled.

Top module: `dual_lut_dac_sel`

## Requirements
- R1: While `rst` is high, and at every edge where `pwr_ready` is low, both DAC codes are 00h at the next clock. A table write done while `pwr_ready` is low is stored but does not appear on either output.
- R2: With `dir_en[k]` = 0, channel k reads row `adc_code[7:2]` of table k, and `dac_codek` shows that byte one clock after `adc_code` is presented.
- R3: With `dir_en[k]` = 1, channel k reads row `dir_rowk` of table k, one clock after the row is presented, whatever the value of `adc_code`.
- R4: With `dir_en[k]` = 0, `dir_rowk` has no effect: changing it alone leaves `dac_codek` unchanged.
- R5: The two channels pick their row source independently; one may follow the ADC while the other uses its direct row.
- R6: When `tbl_we` is 1, `tbl_wdata` is stored at row `tbl_row` of table 0 if `tbl_sel` = 0, or of table 1 if `tbl_sel` = 1; the other table is not modified.
- R7: A write to the row a channel is reading in that cycle appears on that channel's code at the same edge that stores it, and stays there afterwards.
- R8: When `pwr_ready` rises again after being low, the outputs return to the stored table bytes at the next clock; table contents survive the low period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the output codes |
| pwr_ready | input | 1 | Power-up complete; low forces both codes to 00h |
| adc_code | input | 8 | Latest ADC conversion result |
| dir_en | input | 2 | Per-channel row source: 1 direct row, 0 ADC-derived |
| dir_row0 | input | 6 | Direct row for channel 0 |
| dir_row1 | input | 6 | Direct row for channel 1 |
| tbl_we | input | 1 | Table write strobe |
| tbl_sel | input | 1 | Table selected by the write: 0 or 1 |
| tbl_row | input | 6 | Row written |
| tbl_wdata | input | 8 | Byte written |
| dac_code0 | output | 8 | Registered DAC code of channel 0 |
| dac_code1 | output | 8 | Registered DAC code of channel 1 |

## Verification
The two functions that can meet in one cycle are a host table write and a channel's read of that same row. The bench steers a channel to a row, through the ADC code in one case and through the direct row in another, and writes a new byte to exactly that row in that cycle. It expects the new byte on that channel at the very next edge and the unchanged byte on the other channel, whose table shares the row number but was not written.

// File: rtl/lut_sel_pkg.sv
`timescale 1ns/1ps
package lut_sel_pkg;

    localparam int ROW_W    = 6;
    localparam int CODE_W   = 8;
    localparam int ADC_W    = 8;
    localparam int NUM_CH   = 2;
    localparam int DEPTH    = 1 << ROW_W;
    localparam int CH_SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    typedef logic [ROW_W-1:0]    row_t;
    typedef logic [CODE_W-1:0]   code_t;
    typedef logic [ADC_W-1:0]    adc_t;
    typedef logic [CH_SEL_W-1:0] ch_sel_t;

    typedef enum logic {
        SRC_ADC    = 1'b0,
        SRC_DIRECT = 1'b1
    } row_src_e;

    typedef struct packed {
        row_src_e src;
        row_t     direct_row;
    } row_cfg_t;

    typedef struct packed {
        logic    en;
        ch_sel_t sel;
        row_t    row;
        code_t   data;
    } tbl_wr_t;

    function automatic row_t adc_to_row(input adc_t a);
        return a[ADC_W-1 -: ROW_W];
    endfunction

endpackage

// File: rtl/lut_row_mux.sv
`timescale 1ns/1ps
module lut_row_mux
    import lut_sel_pkg::*;
(
    input  row_cfg_t cfg,
    input  adc_t     adc_code,
    output row_t     row
);

    always_comb begin
        unique case (cfg.src)
            SRC_DIRECT: row = cfg.direct_row;
            default:    row = adc_to_row(adc_code);
        endcase
    end

endmodule

// File: rtl/lut_table.sv
`timescale 1ns/1ps
module lut_table
    import lut_sel_pkg::*;
#(
    parameter int TBL_ID = 0
) (
    input  logic    clk,
    input  tbl_wr_t wr,
    input  row_t    rd_row,
    output code_t   rd_data
);

    code_t mem [DEPTH];
    logic  we_here;
    logic  hit;

    assign we_here = wr.en && (wr.sel == ch_sel_t'(TBL_ID));
    assign hit     = we_here && (wr.row == rd_row);

    always_ff @(posedge clk) begin
        if (we_here) begin
            mem[wr.row] <= wr.data;
        end
    end

    // Forward a write that targets the row being read this cycle.
    assign rd_data = hit ? wr.data : mem[rd_row];

endmodule

// File: rtl/dac_code_reg.sv
`timescale 1ns/1ps
module dac_code_reg
    import lut_sel_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  pwr_ready,
    input  code_t d,
    output code_t q
);

    always_ff @(posedge clk) begin
        if (rst || !pwr_ready) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/dual_lut_dac_sel.sv
`timescale 1ns/1ps
module dual_lut_dac_sel
    import lut_sel_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pwr_ready,
    input  logic [7:0] adc_code,
    input  logic [1:0] dir_en,
    input  logic [5:0] dir_row0,
    input  logic [5:0] dir_row1,
    input  logic       tbl_we,
    input  logic       tbl_sel,
    input  logic [5:0] tbl_row,
    input  logic [7:0] tbl_wdata,
    output logic [7:0] dac_code0,
    output logic [7:0] dac_code1
);

    row_cfg_t cfg     [NUM_CH];
    row_t     row_sel [NUM_CH];
    code_t    rd_byte [NUM_CH];
    code_t    code_q  [NUM_CH];
    tbl_wr_t  wr;

    assign wr.en   = tbl_we;
    assign wr.sel  = ch_sel_t'(tbl_sel);
    assign wr.row  = tbl_row;
    assign wr.data = tbl_wdata;

    assign cfg[0].src        = row_src_e'(dir_en[0]);
    assign cfg[0].direct_row = dir_row0;
    assign cfg[1].src        = row_src_e'(dir_en[1]);
    assign cfg[1].direct_row = dir_row1;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : gen_ch
        lut_row_mux u_mux (
            .cfg      (cfg[ch]),
            .adc_code (adc_code),
            .row      (row_sel[ch])
        );

        lut_table #(.TBL_ID(ch)) u_tbl (
            .clk     (clk),
            .wr      (wr),
            .rd_row  (row_sel[ch]),
            .rd_data (rd_byte[ch])
        );

        dac_code_reg u_out (
            .clk       (clk),
            .rst       (rst),
            .pwr_ready (pwr_ready),
            .d         (rd_byte[ch]),
            .q         (code_q[ch])
        );
    end

    assign dac_code0 = code_q[0];
    assign dac_code1 = code_q[1];

endmodule

// File: rtl/dual_lut_chk.sv
`timescale 1ns/1ps
module dual_lut_chk (
    input logic       clk,
    input logic       rst,
    input logic       pwr_ready,
    input logic [7:0] adc_code,
    input logic [1:0] dir_en,
    input logic [5:0] dir_row0,
    input logic [5:0] dir_row1,
    input logic       tbl_we,
    input logic       tbl_sel,
    input logic [5:0] tbl_row,
    input logic [7:0] tbl_wdata,
    input logic [7:0] dac_code0,
    input logic [7:0] dac_code1
);

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        rst |=> (dac_code0 == 8'h00 && dac_code1 == 8'h00));

    // R1
    not_ready_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !pwr_ready |=> (dac_code0 == 8'h00 && dac_code1 == 8'h00));

    // R4
    adc_mode_row_ignored0_chk: assert property (@(posedge clk) disable iff (rst)
        (pwr_ready && $past(pwr_ready) && !$past(rst) && !tbl_we && !dir_en[0]
         && $stable(dir_en) && $stable(adc_code)) |=> $stable(dac_code0));

    // R4
    adc_mode_row_ignored1_chk: assert property (@(posedge clk) disable iff (rst)
        (pwr_ready && $past(pwr_ready) && !$past(rst) && !tbl_we && !dir_en[1]
         && $stable(dir_en) && $stable(adc_code)) |=> $stable(dac_code1));

    // R3
    direct_adc_ignored0_chk: assert property (@(posedge clk) disable iff (rst)
        (pwr_ready && $past(pwr_ready) && !$past(rst) && !tbl_we && dir_en[0]
         && $stable(dir_en) && $stable(dir_row0)) |=> $stable(dac_code0));

    // R7
    bypass_direct0_chk: assert property (@(posedge clk) disable iff (rst)
        (pwr_ready && tbl_we && !tbl_sel && dir_en[0] && dir_row0 == tbl_row)
        |=> dac_code0 == $past(tbl_wdata));

    // R7
    bypass_adc1_chk: assert property (@(posedge clk) disable iff (rst)
        (pwr_ready && tbl_we && tbl_sel && !dir_en[1] && adc_code[7:2] == tbl_row)
        |=> dac_code1 == $past(tbl_wdata));

endmodule

bind dual_lut_dac_sel dual_lut_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .pwr_ready (pwr_ready),
    .adc_code  (adc_code),
    .dir_en    (dir_en),
    .dir_row0  (dir_row0),
    .dir_row1  (dir_row1),
    .tbl_we    (tbl_we),
    .tbl_sel   (tbl_sel),
    .tbl_row   (tbl_row),
    .tbl_wdata (tbl_wdata),
    .dac_code0 (dac_code0),
    .dac_code1 (dac_code1)
);

// File: tb/dual_lut_dac_sel_test.sv
`timescale 1ns/1ps
module dual_lut_dac_sel_test;

    logic       clk = 1'b0;
    logic       rst;
    logic       pwr_ready;
    logic [7:0] adc_code;
    logic [1:0] dir_en;
    logic [5:0] dir_row0;
    logic [5:0] dir_row1;
    logic       tbl_we;
    logic       tbl_sel;
    logic [5:0] tbl_row;
    logic [7:0] tbl_wdata;
    logic [7:0] dac_code0;
    logic [7:0] dac_code1;

    logic [7:0] m0 [64];
    logic [7:0] m1 [64];

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    dual_lut_dac_sel uut (
        .clk       (clk),
        .rst       (rst),
        .pwr_ready (pwr_ready),
        .adc_code  (adc_code),
        .dir_en    (dir_en),
        .dir_row0  (dir_row0),
        .dir_row1  (dir_row1),
        .tbl_we    (tbl_we),
        .tbl_sel   (tbl_sel),
        .tbl_row   (tbl_row),
        .tbl_wdata (tbl_wdata),
        .dac_code0 (dac_code0),
        .dac_code1 (dac_code1)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] model(input int ch);
        logic [5:0] r;
        if (rst || !pwr_ready) return 8'h00;
        if (ch == 0) begin
            r = dir_en[0] ? dir_row0 : adc_code[7:2];
            return m0[r];
        end
        r = dir_en[1] ? dir_row1 : adc_code[7:2];
        return m1[r];
    endfunction

    // Apply the present inputs at one edge, update the model, check both outputs.
    task automatic cycle(input string req);
        logic [7:0] e0;
        logic [7:0] e1;
        if (tbl_we) begin
            if (tbl_sel) m1[tbl_row] = tbl_wdata;
            else         m0[tbl_row] = tbl_wdata;
        end
        e0 = model(0);
        e1 = model(1);
        @(posedge clk);
        #1;
        tbl_we = 1'b0;
        chk(req, dac_code0, e0);
        chk(req, dac_code1, e1);
    endtask

    initial begin
        rst = 1'b1; pwr_ready = 1'b0; adc_code = 8'h00; dir_en = 2'b00;
        dir_row0 = '0; dir_row1 = '0;
        tbl_we = 1'b0; tbl_sel = 1'b0; tbl_row = '0; tbl_wdata = '0;
        for (int i = 0; i < 64; i++) begin
            m0[i] = 8'h00;
            m1[i] = 8'h00;
        end

        // R1: reset and not-ready hold the codes at zero
        pwr_ready = 1'b1;
        repeat (3) cycle("R1");
        rst = 1'b0; pwr_ready = 1'b0;
        cycle("R1");

        // R6: fill both tables while not ready; R1: outputs stay zero
        for (int i = 0; i < 64; i++) begin
            tbl_we = 1'b1; tbl_sel = 1'b0; tbl_row = 6'(i);
            tbl_wdata = 8'((i * 37 + 5) & 8'hff);
            cycle("R1");
            tbl_we = 1'b1; tbl_sel = 1'b1; tbl_row = 6'(i);
            tbl_wdata = 8'((i * 91 + 200) & 8'hff) ^ 8'h5a;
            cycle("R1");
        end
        pwr_ready = 1'b1;

        // R2, R4: ADC sweep with the direct rows wandering
        dir_en = 2'b00;
        for (int i = 0; i < 256; i++) begin
            adc_code = 8'(i);
            dir_row0 = 6'(i * 13);
            dir_row1 = ~6'(i);
            cycle("R2_R4");
        end

        // R4: only the direct row changes in ADC mode
        adc_code = 8'h9c;
        for (int i = 0; i < 64; i++) begin
            dir_row0 = 6'(i);
            dir_row1 = 6'(63 - i);
            cycle("R4");
        end

        // R3: direct sweep with the ADC code wandering
        dir_en = 2'b11;
        for (int i = 0; i < 64; i++) begin
            dir_row0 = 6'(i);
            dir_row1 = 6'(i * 5 + 3);
            adc_code = 8'(i * 29);
            cycle("R3");
        end

        // R5: mixed sources in both arrangements
        for (int k = 0; k < 2; k++) begin
            dir_en = (k == 0) ? 2'b01 : 2'b10;
            for (int i = 0; i < 64; i++) begin
                adc_code = 8'(255 - i * 4);
                dir_row0 = 6'(i * 7);
                dir_row1 = 6'(i * 11);
                cycle("R5");
            end
        end

        // R6, R7: direct-mode collision on table 1, table 0 same row untouched
        dir_en = 2'b11; dir_row0 = 6'd10; dir_row1 = 6'd10;
        cycle("R3");
        tbl_we = 1'b1; tbl_sel = 1'b1; tbl_row = 6'd10; tbl_wdata = 8'hc3;
        cycle("R6_R7");
        cycle("R7");

        // R7: ADC-mode collision on table 0
        dir_en = 2'b00; adc_code = 8'h50;
        cycle("R2");
        tbl_we = 1'b1; tbl_sel = 1'b0; tbl_row = 6'd20; tbl_wdata = 8'h3e;
        cycle("R6_R7");
        cycle("R7");

        // R6: write to a row nobody reads, then read it back
        tbl_we = 1'b1; tbl_sel = 1'b0; tbl_row = 6'd40; tbl_wdata = 8'h77;
        cycle("R6");
        dir_en = 2'b11; dir_row0 = 6'd40; dir_row1 = 6'd40;
        cycle("R6");

        // R8: drop and restore power-ready
        pwr_ready = 1'b0;
        cycle("R1");
        cycle("R1");
        pwr_ready = 1'b1;
        cycle("R8");
        dir_en = 2'b00; adc_code = 8'hff;
        cycle("R8");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule